// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer with Clock Output

This block is a 16-bit timer/counter with a small write port for its control bits, its count register, its reload/capture register and its two event flags. It advances on an internal tick enable or on falling edges of an external count pin. That pin is passed through a two-flop synchronizer and an edge detector, so it yields at most one count per clock. Five operating modes come from the control bits: stopped, auto-reload counting up, auto-reload counting up or down under an external direction pin, capture on a falling edge of an external capture pin, and baud-rate generation for two serial ports.

When the overflow/underflow flag is set, it can be used as an interrupt request. In up/down mode an extension flag changes state on every wrap and acts as a seventeenth count bit. In capture mode the same flag records that a capture took place. A clock-output pin can toggle on every wrap to give a 50% duty clock. While that clock output runs, and in baud mode, wraps leave the overflow flag unchanged. The baud tick output pulses once every sixteen overflows. When the clock output and baud mode run together, the clock-output frequency is therefore eight times the baud tick rate. Two select outputs tell each serial port (receive and transmit) whether to take its baud clock from this timer.

Control word (write address 0): bit 0 run, bit 1 capture select, bit 2 direction enable, bit 3 receive baud select, bit 4 transmit baud select, bit 5 clock-output enable, bit 6 external count select. Address 1 writes the count register, address 2 writes the reload/capture register, and address 3 writes the flags (bit 0 overflow flag, bit 1 extension flag).

Top module: `tmr16_multi`

## Requirements
- R1: After reset the count register, the reload register, both flags, the clock output, the baud tick and both select outputs are 0.
- R2: With run (control bit 0) at 0, count events leave the count register unchanged.
- R3: In up mode (run=1, bits 1..4 at 0), each count event adds one. An event at 0xFFFF loads the reload register and sets the overflow flag.
- R4: In up/down mode (run=1, bit 2=1, bits 1,3,4 at 0), the synchronized direction pin selects up (1) or down (0). Counting down from a value equal to the reload register loads 0xFFFF. Counting up from 0xFFFF loads the reload register. Both wraps set the overflow flag and invert the extension flag.
- R5: In capture mode (run=1, bit 1=1, bits 3,4 at 0), a synchronized falling edge on the capture pin copies the count into the reload register and sets the extension flag, and counting continues. An overflow from 0xFFFF loads 0 and sets the overflow flag.
- R6: When bit 3 or bit 4 is 1 (with run=1), the timer is in baud mode whatever bits 1 and 2 hold. It counts up with reload, leaves the overflow flag unchanged, and pulses the baud tick for one cycle on every sixteenth overflow.
- R7: With run=1, bit 5=1 and bit 6=0, the clock output inverts on every wrap and the overflow flag is not set. With bit 6=1, the clock output holds its value.
- R8: With clock output and baud mode both active, the clock output completes eight periods per baud tick.
- R9: The receive select output follows bit 3 and the transmit select output follows bit 4, independently.
- R10: With bit 6=1 and bit 5=0, the count advances once per falling edge of the synchronized count pin and ignores the internal tick.
- R11: A count register write in the same cycle as a count event loads the written value. A flag write sets both flags to the written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 count, 2 reload, 3 flags |
| cfg_wdata | input | 16 | Write data |
| tick | input | 1 | Internal count enable, one count per high cycle |
| ext_cnt_in | input | 1 | External count pin (asynchronous) |
| ext_dir_in | input | 1 | External direction pin, 1 = up (asynchronous) |
| ext_cap_in | input | 1 | External capture pin (asynchronous) |
| clk_out | output | 1 | Toggling clock output |
| baud_tick | output | 1 | One-cycle baud pulse for the serial ports |
| rx_use_tmr | output | 1 | Receive baud source select |
| tx_use_tmr | output | 1 | Transmit baud source select |
| ovf_flag | output | 1 | Overflow/underflow flag |
| ext_flag | output | 1 | Extension flag (17th bit or capture event) |
| tmr_q | output | 16 | Count register |
| rld_q | output | 16 | Reload/capture register |

## Verification
The hardest situations to reach from the ports are the wrap-related ones: an underflow against the reload value, the ratio of clock-output toggles to baud pulses, and the baud pulse that comes only every sixteenth overflow. Reaching them by free counting would take tens of thousands of ticks. The stimulus instead writes the count and reload registers next to the wrap point, and with a reload of 0xFFFF it makes every tick an overflow. Each tick's expected count is computed in the bench, and toggles and pulses are counted across long tick sweeps. The external pins are held long enough to pass the synchronizer, so that one edge gives exactly one count.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  typedef enum logic [2:0] {
    M_STOP,
    M_UP,
    M_UPDN,
    M_CAP,
    M_BAUD
  } mode_e;

  typedef struct packed {
    logic ext_sel;
    logic oe;
    logic tclk;
    logic rclk;
    logic dcen;
    logic cap_sel;
    logic run;
  } ctrl_t;

  localparam int CTRL_W = 7;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_TMR  = 2'd1;
  localparam logic [1:0] ADDR_RLD  = 2'd2;
  localparam logic [1:0] ADDR_FLAG = 2'd3;
endpackage

// File: rtl/tmr16_sync_fall.sv
module tmr16_sync_fall #(
  parameter int N = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] fall_o
);
  localparam int SH_W = STAGES + 1;

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic [SH_W-1:0] sh_q, sh_d;

    always_comb sh_d = {sh_q[SH_W-2:0], pin_i[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '1;
      else        sh_q <= sh_d;
    end

    assign lvl_o[g]  = sh_q[STAGES-1];
    assign fall_o[g] = sh_q[STAGES] & ~sh_q[STAGES-1];

    // R10: a falling edge yields a single one-cycle event
    p_one_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o[g] |=> !fall_o[g]);
  end
endmodule

// File: rtl/tmr16_mode_dec.sv
module tmr16_mode_dec
  import tmr16_pkg::*;
(
  input  tmr16_pkg::ctrl_t ctrl_i,
  output tmr16_pkg::mode_e mode_o,
  output logic             co_on_o
);
  always_comb begin
    if (!ctrl_i.run)                     mode_o = M_STOP;
    else if (ctrl_i.rclk || ctrl_i.tclk) mode_o = M_BAUD;
    else if (ctrl_i.cap_sel)             mode_o = M_CAP;
    else if (ctrl_i.dcen)                mode_o = M_UPDN;
    else                                 mode_o = M_UP;
  end

  assign co_on_o = ctrl_i.run & ctrl_i.oe & ~ctrl_i.ext_sel;
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
#(
  parameter int W = 16,
  parameter int BAUD_DIV = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr16_pkg::mode_e mode_i,
  input  logic             co_on_i,
  input  logic             cnt_ev_i,
  input  logic             dir_up_i,
  input  logic             cap_ev_i,
  input  logic             tmr_we_i,
  input  logic             rld_we_i,
  input  logic             flag_we_i,
  input  logic [W-1:0]     wdata_i,
  output logic [W-1:0]     tmr_o,
  output logic [W-1:0]     rld_o,
  output logic             ovf_o,
  output logic             ext_o,
  output logic             clk_out_o,
  output logic             baud_tick_o
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam int PW = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(BAUD_DIV - 1);

  logic [W-1:0]  tmr_q, tmr_d, rld_q, rld_d;
  logic          ovf_q, ovf_d, ext_q, ext_d, co_q, co_d, btk_q, btk_d;
  logic [PW-1:0] pre_q, pre_d;
  logic          ev, up_dir, ovf_ev, unf_ev, wrap, quiet, cap_hit;

  always_comb begin
    ev      = (mode_i != M_STOP) && cnt_ev_i;
    up_dir  = (mode_i != M_UPDN) || dir_up_i;
    ovf_ev  = ev && up_dir && (tmr_q == MAXV);
    unf_ev  = ev && !up_dir && (tmr_q == rld_q);
    wrap    = ovf_ev || unf_ev;
    quiet   = (mode_i == M_BAUD) || co_on_i;
    cap_hit = (mode_i == M_CAP) && cap_ev_i;

    if (tmr_we_i)    tmr_d = wdata_i;
    else if (ovf_ev) tmr_d = (mode_i == M_CAP) ? '0 : rld_q;
    else if (unf_ev) tmr_d = MAXV;
    else if (ev)     tmr_d = up_dir ? tmr_q + 1'b1 : tmr_q - 1'b1;
    else             tmr_d = tmr_q;

    if (cap_hit)       rld_d = tmr_q;
    else if (rld_we_i) rld_d = wdata_i;
    else               rld_d = rld_q;

    if (flag_we_i)          ovf_d = wdata_i[0];
    else if (wrap && !quiet) ovf_d = 1'b1;
    else                    ovf_d = ovf_q;

    if (flag_we_i)                     ext_d = wdata_i[1];
    else if (mode_i == M_UPDN && wrap) ext_d = ~ext_q;
    else if (cap_hit)                  ext_d = 1'b1;
    else                               ext_d = ext_q;

    co_d = (co_on_i && wrap) ? ~co_q : co_q;

    if (mode_i != M_BAUD) pre_d = '0;
    else if (ovf_ev)      pre_d = (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
    else                  pre_d = pre_q;

    btk_d = (mode_i == M_BAUD) && ovf_ev && (pre_q == PRE_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
      rld_q <= '0;
      ovf_q <= 1'b0;
      ext_q <= 1'b0;
      co_q  <= 1'b0;
      pre_q <= '0;
      btk_q <= 1'b0;
    end else begin
      tmr_q <= tmr_d;
      rld_q <= rld_d;
      ovf_q <= ovf_d;
      ext_q <= ext_d;
      co_q  <= co_d;
      pre_q <= pre_d;
      btk_q <= btk_d;
    end
  end

  assign tmr_o       = tmr_q;
  assign rld_o       = rld_q;
  assign ovf_o       = ovf_q;
  assign ext_o       = ext_q;
  assign clk_out_o   = co_q;
  assign baud_tick_o = btk_q;

  // R2: stopped timer holds its count
  p_stop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == M_STOP && !tmr_we_i) |=> $stable(tmr_o));

  // R4: down count from the reload value lands on all ones
  p_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == M_UPDN && cnt_ev_i && !dir_up_i && tmr_o == rld_o && !tmr_we_i)
    |=> tmr_o == MAXV);

  // R6 and R7: baud and clock-out modes leave the overflow flag alone
  p_no_ovf_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == M_BAUD || co_on_i) && !flag_we_i) |=> $stable(ovf_o));

  // R6: baud tick is a single-cycle pulse
  p_baud_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick_o |=> !baud_tick_o);

  // R7: clock output frozen while clock-out is inactive
  p_clkout_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !co_on_i |=> $stable(clk_out_o));
endmodule

// File: rtl/tmr16_multi.sv
module tmr16_multi
  import tmr16_pkg::*;
#(
  parameter int W = 16,
  parameter int BAUD_DIV = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [1:0]   cfg_addr,
  input  logic [W-1:0] cfg_wdata,
  input  logic         tick,
  input  logic         ext_cnt_in,
  input  logic         ext_dir_in,
  input  logic         ext_cap_in,
  output logic         clk_out,
  output logic         baud_tick,
  output logic         rx_use_tmr,
  output logic         tx_use_tmr,
  output logic         ovf_flag,
  output logic         ext_flag,
  output logic [W-1:0] tmr_q,
  output logic [W-1:0] rld_q
);
  localparam int NPIN = 3;
  localparam int IX_CNT = 0;
  localparam int IX_DIR = 1;
  localparam int IX_CAP = 2;

  ctrl_t ctrl_q, ctrl_d;
  mode_e mode;
  logic  co_on, cnt_ev;
  logic [NPIN-1:0] pin_lvl, pin_fall;
  logic  unused_sync;

  always_comb begin
    if (cfg_we && cfg_addr == ADDR_CTRL) ctrl_d = ctrl_t'(cfg_wdata[CTRL_W-1:0]);
    else                                 ctrl_d = ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  tmr16_sync_fall #(.N(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  ({ext_cap_in, ext_dir_in, ext_cnt_in}),
    .lvl_o  (pin_lvl),
    .fall_o (pin_fall)
  );

  assign unused_sync = ^{pin_lvl[IX_CNT], pin_lvl[IX_CAP], pin_fall[IX_DIR]};

  tmr16_mode_dec u_dec (
    .ctrl_i  (ctrl_q),
    .mode_o  (mode),
    .co_on_o (co_on)
  );

  assign cnt_ev = ctrl_q.ext_sel ? (pin_fall[IX_CNT] & ~ctrl_q.oe) : tick;

  tmr16_core #(.W(W), .BAUD_DIV(BAUD_DIV)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode),
    .co_on_i     (co_on),
    .cnt_ev_i    (cnt_ev),
    .dir_up_i    (pin_lvl[IX_DIR]),
    .cap_ev_i    (pin_fall[IX_CAP]),
    .tmr_we_i    (cfg_we && cfg_addr == ADDR_TMR),
    .rld_we_i    (cfg_we && cfg_addr == ADDR_RLD),
    .flag_we_i   (cfg_we && cfg_addr == ADDR_FLAG),
    .wdata_i     (cfg_wdata),
    .tmr_o       (tmr_q),
    .rld_o       (rld_q),
    .ovf_o       (ovf_flag),
    .ext_o       (ext_flag),
    .clk_out_o   (clk_out),
    .baud_tick_o (baud_tick)
  );

  assign rx_use_tmr = ctrl_q.rclk;
  assign tx_use_tmr = ctrl_q.tclk;

  // R9: the two baud source selects track their own control bits
  p_selects_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == ADDR_CTRL) |=> (rx_use_tmr == $past(cfg_wdata[3]))
                                          && (tx_use_tmr == $past(cfg_wdata[4])));
endmodule

// File: tb/tmr16_multi_test.sv
module tmr16_multi_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic        tick = 1'b0;
  logic        ext_cnt_in = 1'b1;
  logic        ext_dir_in = 1'b1;
  logic        ext_cap_in = 1'b1;
  logic        clk_out, baud_tick, rx_use_tmr, tx_use_tmr, ovf_flag, ext_flag;
  logic [15:0] tmr_q, rld_q;

  int errs = 0;
  int checks = 0;
  int n_baud = 0;
  int n_tog = 0;
  logic last_co = 1'b0;
  logic [15:0] e_tmr, e_rld;
  logic e_ovf, e_ext;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr16_multi uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tick(tick), .ext_cnt_in(ext_cnt_in),
    .ext_dir_in(ext_dir_in), .ext_cap_in(ext_cap_in), .clk_out(clk_out),
    .baud_tick(baud_tick), .rx_use_tmr(rx_use_tmr), .tx_use_tmr(tx_use_tmr),
    .ovf_flag(ovf_flag), .ext_flag(ext_flag), .tmr_q(tmr_q), .rld_q(rld_q)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    if (baud_tick) n_baud++;
    if (clk_out !== last_co) n_tog++;
    last_co = clk_out;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1: reset state
    chk("R1 tmr", tmr_q, 0);
    chk("R1 rld", rld_q, 0);
    chk("R1 flags", {ovf_flag, ext_flag}, 0);
    chk("R1 outs", {clk_out, baud_tick, rx_use_tmr, tx_use_tmr}, 0);

    // R2: stopped
    wr(2'd1, 16'h0042);
    for (int i = 0; i < 5; i++) pulse();
    chk("R2 stopped hold", tmr_q, 16'h0042);

    // R3: up mode, sweep of reload values
    for (int k = 0; k < 3; k++) begin
      e_rld = (k == 0) ? 16'hFFF0 : (k == 1) ? 16'h0000 : 16'hFFFE;
      wr(2'd3, 16'h0000);
      wr(2'd0, 16'h0001);
      wr(2'd2, e_rld);
      wr(2'd1, 16'hFFFA);
      e_tmr = 16'hFFFA; e_ovf = 1'b0;
      for (int i = 0; i < 20; i++) begin
        pulse();
        if (e_tmr == 16'hFFFF) begin e_tmr = e_rld; e_ovf = 1'b1; end
        else e_tmr = e_tmr + 1'b1;
        chk("R3 up count", tmr_q, e_tmr);
      end
      chk("R3 ovf flag", ovf_flag, e_ovf);
    end

    // R4: up/down mode
    wr(2'd3, 16'h0000);
    wr(2'd0, 16'h0005);
    wr(2'd2, 16'h0010);
    wr(2'd1, 16'h0013);
    e_tmr = 16'h0013; e_rld = 16'h0010; e_ext = 1'b0; e_ovf = 1'b0;
    for (int p = 0; p < 2; p++) begin
      ext_dir_in = (p == 1);
      idle(4);
      for (int i = 0; i < 8; i++) begin
        pulse();
        if (p == 0) begin
          if (e_tmr == e_rld) begin e_tmr = 16'hFFFF; e_ext = ~e_ext; e_ovf = 1'b1; end
          else e_tmr = e_tmr - 1'b1;
        end else begin
          if (e_tmr == 16'hFFFF) begin e_tmr = e_rld; e_ext = ~e_ext; e_ovf = 1'b1; end
          else e_tmr = e_tmr + 1'b1;
        end
        chk("R4 updown count", tmr_q, e_tmr);
        chk("R4 ext flag", ext_flag, e_ext);
      end
    end
    chk("R4 ovf flag", ovf_flag, e_ovf);

    // R5: capture mode
    wr(2'd3, 16'h0000);
    wr(2'd0, 16'h0003);
    wr(2'd2, 16'h0000);
    wr(2'd1, 16'h1230);
    for (int i = 0; i < 5; i++) pulse();
    ext_cap_in = 1'b0;
    idle(5);
    chk("R5 captured", rld_q, 16'h1235);
    chk("R5 ext flag", ext_flag, 1'b1);
    ext_cap_in = 1'b1;
    idle(4);
    for (int i = 0; i < 3; i++) pulse();
    chk("R5 keeps counting", tmr_q, 16'h1238);
    chk("R5 capture kept", rld_q, 16'h1235);
    wr(2'd1, 16'hFFFF);
    pulse();
    chk("R5 wrap to zero", tmr_q, 16'h0000);
    chk("R5 ovf flag", ovf_flag, 1'b1);

    // R6/R9: baud mode, every tick an overflow
    wr(2'd3, 16'h0000);
    wr(2'd0, 16'h0009);
    wr(2'd2, 16'hFFFF);
    wr(2'd1, 16'hFFFF);
    n_baud = 0;
    for (int i = 0; i < 64; i++) pulse();
    chk("R6 baud pulses", n_baud, 4);
    chk("R6 no ovf", ovf_flag, 1'b0);
    chk("R9 rx select", {rx_use_tmr, tx_use_tmr}, 2'b10);
    wr(2'd0, 16'h0011);
    chk("R9 tx select", {rx_use_tmr, tx_use_tmr}, 2'b01);
    // R6: baud overrides direction enable, counts up with pin low
    ext_dir_in = 1'b0;
    wr(2'd0, 16'h0017);
    wr(2'd2, 16'hFFF0);
    wr(2'd1, 16'hFFF0);
    idle(4);
    pulse();
    chk("R6 baud precedence", tmr_q, 16'hFFF1);

    // R7: clock output
    wr(2'd3, 16'h0000);
    wr(2'd0, 16'h0021);
    wr(2'd2, 16'hFFFF);
    wr(2'd1, 16'hFFFF);
    last_co = clk_out; n_tog = 0;
    for (int i = 0; i < 32; i++) pulse();
    chk("R7 toggles", n_tog, 32);
    chk("R7 no ovf", ovf_flag, 1'b0);

    // R8: combined clock output and baud
    wr(2'd0, 16'h0029);
    last_co = clk_out; n_tog = 0; n_baud = 0;
    for (int i = 0; i < 128; i++) pulse();
    chk("R8 baud pulses", n_baud, 8);
    chk("R8 ratio", n_tog / 2, 8 * n_baud);

    // R7: external count select stops clock output
    wr(2'd0, 16'h0061);
    last_co = clk_out; n_tog = 0;
    for (int i = 0; i < 8; i++) pulse();
    chk("R7 held with ext select", n_tog, 0);

    // R10: external count pin
    wr(2'd0, 16'h0041);
    wr(2'd2, 16'h0000);
    wr(2'd1, 16'h0100);
    for (int i = 0; i < 6; i++) begin
      ext_cnt_in = 1'b0; idle(6);
      if (i == 0) chk("R10 one count per edge", tmr_q, 16'h0101);
      ext_cnt_in = 1'b1; idle(6);
    end
    chk("R10 edge count", tmr_q, 16'h0106);
    for (int i = 0; i < 3; i++) pulse();
    chk("R10 tick ignored", tmr_q, 16'h0106);

    // R11: write priority and flag write
    wr(2'd0, 16'h0001);
    tick = 1'b1;
    wr(2'd1, 16'h0777);
    tick = 1'b0;
    chk("R11 write wins", tmr_q, 16'h0777);
    wr(2'd3, 16'h0003);
    chk("R11 flag set", {ovf_flag, ext_flag}, 2'b11);
    wr(2'd3, 16'h0002);
    chk("R11 flag write", {ovf_flag, ext_flag}, 2'b01);

    summary();
  end
endmodule